// File: doc/BRIEF.md
# Serial Audio Output Port with Mute

This block turns stereo parallel samples of 24 bits into a serial stream on one data line. The bit clock, left/right clock and word clock all come from outside the block. It samples them with its own system clock and detects their edges there. At each inactive bit-clock edge the block moves to the next bit slot, so each bit stays stable across the following active edge.

A stereo frame begins when the left/right clock rises. At that point both channel samples and the mute request are latched, and they stay fixed for the whole frame. Four framing modes set where the most significant bit falls inside each channel half. Bit-clock polarity can be selected. A receiver may keep as many leading bits as it needs and ignore the rest.

The controller is a four-state machine:

- **ST_WAIT**: after reset, output held at zero.
- **ST_LEAD**: zero slots before the first data bit.
- **ST_DATA**: the 24 data bits, MSB first.
- **ST_PAD**: zero slots after the least significant bit.

Its transitions are:

- **WAIT→LEAD**: the first left/right transition seen after reset.
- **any→LEAD**: every left/right transition.
- **LEAD→DATA**: the lead count reaches zero, or in word-clock mode a rising word clock.
- **DATA→PAD**: all 24 bits have been sent.
- **PAD→LEAD**: the next left/right transition.

Top module: `audio_ser_tx`

## Requirements
- R1: After reset `sdo` is 0, and it stays 0 until the first left/right clock transition seen after reset. The first inactive bit-clock edge after reset only records the left/right level.
- R2: Each channel word is 24 bits, sent MSB first, one bit per bit-clock slot. A half shorter than the word delivers the leading bits in order.
- R3: Slots after the LSB within a channel half carry 0.
- R4: `frame_mode` 00 puts the MSB in slot 0. Slot 0 is the slot driven at the inactive edge where the left/right clock changes. `frame_mode` 01 puts the MSB in slot 1, and slot 0 carries 0.
- R5: `frame_mode` 10 puts the MSB in slot 16, and slots 0 to 15 carry 0.
- R6: `frame_mode` 11 puts the MSB in the first slot whose inactive edge finds the word clock high after it was low at the previous one. Earlier slots carry 0.
- R7: With `sclk_inv`=0 the rising bit-clock edge is active and `sdo` changes after falling edges. With `sclk_inv`=1 the two roles swap.
- R8: A high left/right clock marks the left half. Both samples are latched when it rises. Later changes on `left_smp` or `right_smp` do not alter that frame's right channel.
- R9: `mute_in` is sampled when the left/right clock rises. A frame sampled as muted sends 0 in every slot of both halves.
- R10: A change of `mute_in` during a frame does not alter that frame. It takes effect from the next rising left/right clock.
- R11: `sdo` changes only on the system clock cycle after an inactive bit-clock edge is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | External bit clock |
| lrck_in | input | 1 | External left/right clock, high for the left half |
| wck_in | input | 1 | External word clock, used in mode 11 |
| sclk_inv | input | 1 | 0: rising bit-clock edge active; 1: falling edge active |
| frame_mode | input | 2 | 00 MSB in slot 0, 01 MSB in slot 1, 10 MSB in slot 16, 11 word-clock start |
| mute_in | input | 1 | Mute request, sampled at each frame start |
| left_smp | input | 24 | Left channel parallel sample |
| right_smp | input | 24 | Right channel parallel sample |
| sdo | output | 1 | Serial data output |

## Verification
The checker watches every cycle for several properties:

- the output is quiet in the wait and pad states and for the whole of a muted frame;
- the output changes only after a detected inactive bit-clock edge;
- the latched mute flag moves only at a left-half start.

Bit placement is checked only by the bench scenarios, which compare the bits a receiver captures at active edges against words computed from the framing rules. That covers each framing mode, short and long halves, inverted polarity and sample latching. The same applies to the frame-boundary timing of mute requests, seen as whole frames staying intact or fully zero.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

    // Framing selection: position of the MSB inside each channel half
    typedef enum logic [1:0] {
        FM_LEFT     = 2'b00,
        FM_LEFT_DLY = 2'b01,
        FM_RIGHT    = 2'b10,
        FM_WORD     = 2'b11
    } frame_mode_e;

    typedef enum logic [1:0] {
        ST_WAIT = 2'b00,
        ST_LEAD = 2'b01,
        ST_DATA = 2'b10,
        ST_PAD  = 2'b11
    } tx_state_e;

endpackage

// File: rtl/audio_ser_sync.sv
module audio_ser_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic lrck_in,
    input  logic wck_in,
    input  logic sclk_inv,
    output logic tick,
    output logic lr_lvl,
    output logic wck_lvl
);
    localparam int NSIG = 3;
    localparam int CW   = SYNC_STAGES * NSIG;

    logic [CW-1:0]   chain_q;
    logic [NSIG-1:0] raw_in;
    logic [NSIG-1:0] synced;
    logic            sclk_s;
    logic            act_lvl;
    logic            act_q;

    assign raw_in = {wck_in, lrck_in, sclk_in};

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= raw_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[CW-NSIG-1:0], raw_in};
            end
        end
    endgenerate

    assign synced                   = chain_q[CW-1 -: NSIG];
    assign {wck_lvl, lr_lvl, sclk_s} = synced;

    // Active-high view of the bit clock: a 1->0 step is an inactive edge
    assign act_lvl = sclk_s ^ sclk_inv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_lvl;
    end

    assign tick = act_q & ~act_lvl;

endmodule

// File: rtl/audio_ser_latch.sv
module audio_ser_latch #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_left,
    input  logic         load_right,
    input  logic [W-1:0] left_smp,
    input  logic [W-1:0] right_smp,
    input  logic         mute_in,
    output logic [W-1:0] word_next,
    output logic         mute_hold
);
    logic [W-1:0] right_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            right_hold <= '0;
            mute_hold  <= 1'b0;
        end else if (load_left) begin
            right_hold <= right_smp;
            mute_hold  <= mute_in;
        end
    end

    // Word for the half that starts now; a muted frame loads zeros
    always_comb begin
        word_next = '0;
        if (load_left) begin
            word_next = mute_in ? '0 : left_smp;
        end else if (load_right) begin
            word_next = mute_hold ? '0 : right_hold;
        end
    end

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
    parameter int W           = 24,
    parameter int RJ_LEAD     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_in,
    input  logic         lrck_in,
    input  logic         wck_in,
    input  logic         sclk_inv,
    input  logic [1:0]   frame_mode,
    input  logic         mute_in,
    input  logic [W-1:0] left_smp,
    input  logic [W-1:0] right_smp,
    output logic         sdo
);
    import audio_ser_pkg::*;

    localparam int LEAD_W = $clog2(RJ_LEAD + 1);
    localparam int REM_W  = $clog2(W);
    localparam logic [REM_W-1:0]  REM_INIT = REM_W'(W - 1);
    localparam logic [LEAD_W-1:0] LEAD_RJ  = LEAD_W'(RJ_LEAD);

    logic        tick, lr_s, wck_s;
    logic        lr_prev, wck_prev, primed;
    logic        lr_edge, wck_rise, load_left, load_right;
    logic [W-1:0] word_next;
    logic        mute_hold;

    tx_state_e         state_q, state_n, eff_state;
    logic [LEAD_W-1:0] lead_q, lead_n, eff_lead, mode_lead;
    logic [REM_W-1:0]  rem_q, rem_n;
    logic [W-1:0]      sh_q, sh_n, eff_sh;
    logic              sdo_q, sdo_n, start;
    frame_mode_e       mode;

    assign mode = frame_mode_e'(frame_mode);

    audio_ser_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_in),
        .lrck_in  (lrck_in),
        .wck_in   (wck_in),
        .sclk_inv (sclk_inv),
        .tick     (tick),
        .lr_lvl   (lr_s),
        .wck_lvl  (wck_s)
    );

    // Edge tracking of the frame clocks, sampled at inactive edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_prev  <= 1'b0;
            wck_prev <= 1'b0;
            primed   <= 1'b0;
        end else if (tick) begin
            lr_prev  <= lr_s;
            wck_prev <= wck_s;
            primed   <= 1'b1;
        end
    end

    assign lr_edge    = tick & primed & (lr_s != lr_prev);
    assign wck_rise   = wck_s & ~wck_prev;
    assign load_left  = lr_edge & lr_s;
    assign load_right = lr_edge & ~lr_s;

    audio_ser_latch #(.W(W)) latch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_left  (load_left),
        .load_right (load_right),
        .left_smp   (left_smp),
        .right_smp  (right_smp),
        .mute_in    (mute_in),
        .word_next  (word_next),
        .mute_hold  (mute_hold)
    );

    always_comb begin
        unique case (mode)
            FM_LEFT:     mode_lead = '0;
            FM_LEFT_DLY: mode_lead = LEAD_W'(1);
            FM_RIGHT:    mode_lead = LEAD_RJ;
            FM_WORD:     mode_lead = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            lead_q  <= '0;
            rem_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_n;
            lead_q  <= lead_n;
            rem_q   <= rem_n;
            sh_q    <= sh_n;
        end
    end

    // Next-state logic: a left/right edge restarts the half in ST_LEAD
    always_comb begin
        eff_state = state_q;
        eff_lead  = lead_q;
        eff_sh    = sh_q;
        if (lr_edge) begin
            eff_state = ST_LEAD;
            eff_lead  = mode_lead;
            eff_sh    = word_next;
        end
        state_n = state_q;
        lead_n  = lead_q;
        rem_n   = rem_q;
        sh_n    = sh_q;
        sdo_n   = sdo_q;
        start   = 1'b0;
        if (tick) begin
            unique case (eff_state)
                ST_WAIT: begin
                    sdo_n = 1'b0;
                end
                ST_LEAD: begin
                    start = (mode == FM_WORD) ? wck_rise : (eff_lead == '0);
                    if (start) begin
                        sdo_n   = eff_sh[W-1];
                        sh_n    = {eff_sh[W-2:0], 1'b0};
                        rem_n   = REM_INIT;
                        lead_n  = '0;
                        state_n = ST_DATA;
                    end else begin
                        sdo_n   = 1'b0;
                        sh_n    = eff_sh;
                        lead_n  = (eff_lead == '0) ? '0 : eff_lead - 1'b1;
                        state_n = ST_LEAD;
                    end
                end
                ST_DATA: begin
                    if (rem_q == '0) begin
                        sdo_n   = 1'b0;
                        state_n = ST_PAD;
                    end else begin
                        sdo_n = sh_q[W-1];
                        sh_n  = {sh_q[W-2:0], 1'b0};
                        rem_n = rem_q - 1'b1;
                    end
                end
                ST_PAD: begin
                    sdo_n = 1'b0;
                end
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sdo_q <= 1'b0;
        else        sdo_q <= sdo_n;
    end

    assign sdo = sdo_q;

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk
    import audio_ser_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick,
    input logic      sdo,
    input tx_state_e state,
    input logic      mute_hold,
    input logic      load_left
);

    // R1
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sdo);

    // R3
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD) |-> !sdo);

    // R9
    muted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_hold |-> !sdo);

    // R10
    mute_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mute_hold) |-> $past(load_left));

    // R11
    sdo_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(tick));

endmodule

bind audio_ser_tx audio_ser_tx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .sdo       (sdo),
    .state     (state_q),
    .mute_hold (mute_hold),
    .load_left (load_left)
);

// File: tb/audio_ser_tx_tb_top.sv
module audio_ser_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 8;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sclk_in, lrck_in, wck_in, sclk_inv, mute_in;
    logic [1:0]  frame_mode;
    logic [23:0] left_smp, right_smp;
    logic        sdo;

    int tests_run    = 0;
    int tests_failed = 0;
    bit finished     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_ser_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_in    (sclk_in),
        .lrck_in    (lrck_in),
        .wck_in     (wck_in),
        .sclk_inv   (sclk_inv),
        .frame_mode (frame_mode),
        .mute_in    (mute_in),
        .left_smp   (left_smp),
        .right_smp  (right_smp),
        .sdo        (sdo)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One bit slot: inactive edge with frame clocks, then sample, then active edge
    task automatic slot(input logic lr, input logic wk, output logic b);
        sclk_in = 1'b0 ^ sclk_inv;
        lrck_in = lr;
        wck_in  = wk;
        repeat (HALF_BIT) @(negedge clk);
        b = sdo;
        sclk_in = 1'b1 ^ sclk_inv;
        repeat (HALF_BIT) @(negedge clk);
    endtask

    task automatic half(input logic lr, input int n, input int wpos, output logic [63:0] got);
        got = '0;
        for (int k = 0; k < n; k++) begin
            logic b;
            slot(lr, (wpos >= 0) && (k == wpos || k == wpos + 1), b);
            got[k] = b;
        end
    endtask

    function automatic logic [63:0] exp_bits(input logic [23:0] w, input int lead, input int n);
        logic [63:0] r = '0;
        for (int k = 0; k < n; k++) begin
            int p = k - lead;
            if (p >= 0 && p < 24) r[k] = w[23 - p];
        end
        return r;
    endfunction

    task automatic xfer(input logic [1:0] m, input int n, input int wpos,
                        input logic [23:0] l0, input logic [23:0] r0, input logic mu0,
                        input logic [23:0] l1, input logic [23:0] r1, input logic mu1,
                        input logic [23:0] el, input logic [23:0] er, input string req);
        logic [63:0] gl, gr;
        int lead;
        frame_mode = m;
        left_smp = l0; right_smp = r0; mute_in = mu0;
        half(1'b1, n, wpos, gl);
        left_smp = l1; right_smp = r1; mute_in = mu1;
        half(1'b0, n, wpos, gr);
        lead = (m == 2'b00) ? 0 : (m == 2'b01) ? 1 : (m == 2'b10) ? 16 : wpos;
        check(gl == exp_bits(el, lead, n), req, "left half", gl, exp_bits(el, lead, n));
        check(gr == exp_bits(er, lead, n), req, "right half", gr, exp_bits(er, lead, n));
    endtask

    task automatic t_reset;
        logic [63:0] got;
        check(sdo == 1'b0, "R1", "sdo after reset", {63'd0, sdo}, 64'd0);
        half(1'b0, 4, -1, got);
        check(got == 64'd0, "R1", "idle before first transition", got, 64'd0);
    endtask

    task automatic t_left;      // R2 R3 R4
        xfer(2'b00, 32, -1, 24'hA5C3F1, 24'h3C96E7, 1'b0,
             24'hA5C3F1, 24'h3C96E7, 1'b0, 24'hA5C3F1, 24'h3C96E7, "R4");
        xfer(2'b00, 32, -1, 24'h800001, 24'hFFFFFF, 1'b0,
             24'h800001, 24'hFFFFFF, 1'b0, 24'h800001, 24'hFFFFFF, "R3");
    endtask

    task automatic t_left_dly;
        xfer(2'b01, 32, -1, 24'h5A0F33, 24'hC0FFEE, 1'b0,
             24'h5A0F33, 24'hC0FFEE, 1'b0, 24'h5A0F33, 24'hC0FFEE, "R4");
    endtask

    task automatic t_right;
        xfer(2'b10, 48, -1, 24'hD2B4E1, 24'h1E2D3C, 1'b0,
             24'hD2B4E1, 24'h1E2D3C, 1'b0, 24'hD2B4E1, 24'h1E2D3C, "R5");
        xfer(2'b10, 32, -1, 24'h9ABCDE, 24'h654321, 1'b0,
             24'h9ABCDE, 24'h654321, 1'b0, 24'h9ABCDE, 24'h654321, "R5");
    endtask

    task automatic t_word;
        xfer(2'b11, 40, 5, 24'hF0E1D2, 24'h0A1B2C, 1'b0,
             24'hF0E1D2, 24'h0A1B2C, 1'b0, 24'hF0E1D2, 24'h0A1B2C, "R6");
    endtask

    task automatic t_short;
        xfer(2'b00, 16, -1, 24'hB7E15A, 24'h4D2C6E, 1'b0,
             24'hB7E15A, 24'h4D2C6E, 1'b0, 24'hB7E15A, 24'h4D2C6E, "R2");
    endtask

    task automatic t_latch;
        xfer(2'b00, 32, -1, 24'h123456, 24'h789ABC, 1'b0,
             24'hFEDCBA, 24'h0F0F0F, 1'b0, 24'h123456, 24'h789ABC, "R8");
        xfer(2'b00, 32, -1, 24'hFEDCBA, 24'h0F0F0F, 1'b0,
             24'hFEDCBA, 24'h0F0F0F, 1'b0, 24'hFEDCBA, 24'h0F0F0F, "R8");
    endtask

    task automatic t_mute;
        xfer(2'b00, 32, -1, 24'hFFFFFF, 24'hAAAAAA, 1'b1,
             24'hFFFFFF, 24'hAAAAAA, 1'b1, 24'h000000, 24'h000000, "R9");
    endtask

    task automatic t_mute_mid;
        // raised mid-frame: this frame intact
        xfer(2'b00, 32, -1, 24'hC3C3C3, 24'h5E5E5E, 1'b0,
             24'hC3C3C3, 24'h5E5E5E, 1'b1, 24'hC3C3C3, 24'h5E5E5E, "R10");
        // sampled high at frame start, released mid-frame: whole frame zero
        xfer(2'b00, 32, -1, 24'hC3C3C3, 24'h5E5E5E, 1'b1,
             24'hC3C3C3, 24'h5E5E5E, 1'b0, 24'h000000, 24'h000000, "R10");
        xfer(2'b00, 32, -1, 24'hC3C3C3, 24'h5E5E5E, 1'b0,
             24'hC3C3C3, 24'h5E5E5E, 1'b0, 24'hC3C3C3, 24'h5E5E5E, "R10");
    endtask

    task automatic t_inverted;
        logic [63:0] got;
        sclk_inv = 1'b1;
        sclk_in  = ~sclk_in;
        half(1'b0, 3, -1, got);
        xfer(2'b00, 32, -1, 24'h6B8D2F, 24'hE4A719, 1'b0,
             24'h6B8D2F, 24'hE4A719, 1'b0, 24'h6B8D2F, 24'hE4A719, "R7");
        xfer(2'b01, 32, -1, 24'h2F6B8D, 24'h19E4A7, 1'b0,
             24'h2F6B8D, 24'h19E4A7, 1'b0, 24'h2F6B8D, 24'h19E4A7, "R7");
    endtask

    initial begin
        rst_n = 1'b0;
        sclk_inv = 1'b0;
        sclk_in = 1'b1;
        lrck_in = 1'b0;
        wck_in = 1'b0;
        mute_in = 1'b0;
        frame_mode = 2'b00;
        left_smp = '0;
        right_smp = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_left();
        t_left_dly();
        t_right();
        t_word();
        t_short();
        t_latch();
        t_mute();
        t_mute_mid();
        t_inverted();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

endmodule